// File: doc/BRIEF.md
# Four-Beat Burst Offset Generator

This block produces the two lowest address bits of a four-beat burst. When the cycle controller asks for a load, it captures the two low bits of the new external address as the start offset and clears its beat index. Each later cycle with the step request raised moves the beat index forward by one. The current offset is computed from the stored start offset and the beat index, in the order chosen by a mode input.

Two orders are supported from any start offset. The sequential order adds the beat index to the start, modulo four. The interleaved order XORs the beat index with the start. After four steps the beat index returns to zero, so the offset comes back to the start value. The upper address bits are not handled here; they come straight from the address register. The decision of when to load or step belongs to the cycle controller.

Top module: `burst_offset_gen`

## Requirements
- R1: While reset (active-low `rst_n`) is held, and right after it, `offset_o` and `beat_o` are both 0.
- R2: A cycle with `load_i` high makes `offset_o` equal the sampled `start_i` and `beat_o` equal 0 after that clock edge.
- R3: With `order_sel_i` = 0 (sequential), `offset_o` = (start + `beat_o`) mod 4. For example, start 01 gives 01, 10, 11, 00 and start 11 gives 11, 00, 01, 10.
- R4: With `order_sel_i` = 1 (interleaved), `offset_o` = start XOR `beat_o`. For example, start 01 gives 01, 00, 11, 10 and start 10 gives 10, 11, 00, 01.
- R5: A cycle with `step_i` high and `load_i` low adds one to `beat_o` modulo 4. After four steps `offset_o` is back at the start value.
- R6: A cycle with both `step_i` and `load_i` low leaves `beat_o` and `offset_o` unchanged.
- R7: When `load_i` and `step_i` are high in the same cycle, the load wins and the beat index becomes 0. A load in the middle of a burst restarts the sequence from the new start.
- R8: Changing `order_sel_i` in the middle of a burst keeps `beat_o`. `offset_o` is then computed from the same start and beat index in the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture a new start offset and clear the beat index |
| start_i | input | 2 | Low two bits of the external address |
| step_i | input | 1 | Advance the beat index by one |
| order_sel_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| offset_o | output | 2 | Current low address offset |
| beat_o | output | 2 | Current beat index |

## Verification
Full four-step bursts are run in both orders from every start offset. This separates the modulo-four sum from the XOR, because the two orders disagree for starts 01 and 11, and it also shows the wrap back to the start. Runs of idle cycles mixed with steps show that holding differs from stepping. Loads issued together with steps, and loads issued mid-burst, show that a load has priority and restarts the sequence. An order flip in the middle of a burst, made with the beat index held, shows that the index is kept and only the mapping changes.

// File: rtl/burst_pkg.sv
package burst_pkg;
    parameter int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef struct packed {
        ofs_t start;
        ofs_t beat;
    } ctr_state_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  ofs_t start_i,
    input  logic step_i,
    output ofs_t start_o,
    output ofs_t beat_o
);
    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.start = start_i;
            st_d.beat  = '0;
        end else if (step_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign beat_o  = st_q.beat;

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == '0 && start_o == $past(start_i)));
    assert_step_adds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i) |=> (beat_o == ofs_t'($past(beat_o) + 1'b1)));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(beat_o) && $stable(start_o)));
    assert_load_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && step_i) |=> (beat_o == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  logic order_sel_i,
    input  ofs_t start_i,
    input  ofs_t beat_i,
    output ofs_t offset_o
);
    always_comb begin
        if (order_sel_i) offset_o = start_i ^ beat_i;
        else             offset_o = start_i + beat_i;
    end
endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] start_i,
    input  logic       step_i,
    input  logic       order_sel_i,
    output logic [1:0] offset_o,
    output logic [1:0] beat_o
);
    ofs_t start_w, beat_w, offset_w;

    burst_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .step_i  (step_i),
        .start_o (start_w),
        .beat_o  (beat_w)
    );

    burst_order_map u_map (
        .order_sel_i (order_sel_i),
        .start_i     (start_w),
        .beat_i      (beat_w),
        .offset_o    (offset_w)
    );

    assign offset_o = offset_w;
    assign beat_o   = beat_w;

    assert_load_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (offset_o == $past(start_i)));
    assert_wrap_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && beat_o == 2'd3) |=> (offset_o == start_w));
    assert_beat_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i && order_sel_i != $past(order_sel_i)) |=> $stable(beat_o));
endmodule

// File: tb/burst_offset_gen_tb_top.sv
module burst_offset_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [1:0] start_i = 2'd0;
    logic       step_i = 1'b0;
    logic       order_sel_i = 1'b0;
    logic [1:0] offset_o;
    logic [1:0] beat_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int m_start = 0;
    int m_beat = 0;

    always #4 clk = ~clk;

    burst_offset_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .step_i(step_i), .order_sel_i(order_sel_i),
        .offset_o(offset_o), .beat_o(beat_o)
    );

    function automatic int exp_ofs(int s, int b, bit il);
        if (il) return s ^ b;
        return (s + b) % 4;
    endfunction

    task automatic check(string tag);
        int eo = exp_ofs(m_start, m_beat, order_sel_i);
        checks++;
        if (int'(offset_o) != eo || int'(beat_o) != m_beat) begin
            failures++;
            $display("FAIL %s: offset=%0d beat=%0d expected offset=%0d beat=%0d",
                     tag, offset_o, beat_o, eo, m_beat);
        end
    endtask

    // drive at a falling edge, clock once, model, compare at the next falling edge
    task automatic cyc(bit ld, int st, bit stp, string tag);
        load_i  = ld;
        start_i = 2'(st);
        step_i  = stp;
        @(posedge clk);
        if (ld) begin
            m_start = st;
            m_beat  = 0;
        end else if (stp) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1 after reset");

        for (int md = 0; md < 2; md++) begin
            order_sel_i = md[0];
            for (int s = 0; s < 4; s++) begin
                cyc(1, s, 0, "R2 load");
                for (int k = 0; k < 4; k++)
                    cyc(0, 0, 1, md ? "R4 interleaved step" : "R3 sequential step");
                checks++;
                if (int'(offset_o) != s) begin
                    failures++;
                    $display("FAIL R5 wrap: offset=%0d expected=%0d", offset_o, s);
                end
            end
        end

        order_sel_i = 1'b0;
        cyc(1, 2, 0, "R2 load start 2");
        cyc(0, 0, 1, "R5 step");
        cyc(0, 3, 0, "R6 hold");
        cyc(0, 1, 0, "R6 hold again");
        cyc(0, 0, 1, "R5 step after hold");

        cyc(1, 1, 1, "R7 load with step");
        cyc(0, 0, 1, "R7 step after load");
        cyc(0, 0, 1, "R7 step");
        cyc(1, 3, 0, "R7 mid-burst reload");
        cyc(0, 0, 1, "R7 step from new start");

        cyc(1, 1, 0, "R8 load");
        cyc(0, 0, 1, "R8 step");
        order_sel_i = 1'b1;
        #1;
        check("R8 order flip immediate");
        cyc(0, 0, 0, "R8 beat kept after flip");
        cyc(0, 0, 1, "R8 step in new order");
        order_sel_i = 1'b0;
        cyc(0, 0, 1, "R8 flip back and step");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule